// File: doc/BRIEF.md
# Masked Interrupt Vector Encoder

This block gathers sixteen interrupt request lines into a pending register, one bit per line. A line becomes pending on its rising edge and stays pending until software acknowledges the byte-wide half that holds it. A sixteen-bit enable mask decides which pending lines count. Software reaches the mask through two byte-wide windows, one for lines 7..0 and one for lines 15..8. Each window has a command slot at offset 0, which acknowledges that half, and a mask slot at offset 1. A byte written to a mask slot is stored inverted, so a written 1 disables its line. Mask bits return to all ones at reset.

A word-wide read port returns one of three values. The first is the full enable mask. The second is a vector: the index of the lowest-numbered line that is both pending and enabled, with the lowest index having the highest priority. The third is a code taken from a separate fifteen-input source register: for the lowest set source input i, the value is (i+1) shifted left by two, and it is 0 when no source input is set. A registered summary interrupt goes high whenever a pending line is also enabled.

Top module: `irq_vec_encoder`

## Requirements
- R1: After reset the mask reads 0xFFFF, the vector reads 0, the source code reads 0 and irq_o is low.
- R2: A write with wr_hi=0 and wr_off=1 stores the bitwise inverse of wr_data into mask bits 7:0 and leaves bits 15:8 unchanged.
- R3: A write with wr_hi=1 and wr_off=1 stores the bitwise inverse of wr_data into mask bits 15:8 and leaves bits 7:0 unchanged.
- R4: A read with rd_sel=0 returns the full 16-bit enable mask.
- R5: A rising edge on req[i] makes line i pending at the next clock edge. Holding the line high does not make it pending again once it has been cleared. A pending line stays pending until its half is acknowledged.
- R6: A write with wr_off=0 clears pending bits 7:0 when wr_hi=0, or bits 15:8 when wr_hi=1. It leaves the other half unchanged, and the written data has no effect.
- R7: A rising edge that arrives in the same cycle as an acknowledge of its half still leaves the line pending.
- R8: A read with rd_sel=1 returns, zero-extended, the lowest index i for which line i is both pending and enabled, or 0 when there is no such line.
- R9: src_req is sampled into a source register on each clock. A read with rd_sel=2 returns (i+1)<<2 for the lowest set bit i of that register, or 0 when no bit is set.
- R10: irq_o is high in the cycle after pending AND mask is nonzero, and low in the cycle after it is zero.
- R11: rd_data and rd_valid are registered. A read requested with rd_en returns its value one cycle later, with rd_valid high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 16 | Interrupt request lines, rising-edge sensitive |
| src_req | input | 15 | Source inputs scanned for the source code |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Selects the window: 0 for lines 7..0, 1 for lines 15..8 |
| wr_off | input | 1 | Slot within the window: 0 for command (acknowledge), 1 for mask |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Read select: 0 for mask, 1 for vector, 2 for source code, 3 reads zero |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High in the cycle in which rd_data holds the result of a read |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
A request edge becomes pending at the next clock edge. A read issued after that sees the new state one cycle after rd_en, and irq_o follows the pending state one cycle later, so the summary is checked two edges after the request is driven. A mask write or an acknowledge takes effect at its own edge, and any read issued after it sees the new value. A change on src_req needs one edge to reach the source register and a second edge to reach rd_data. Each read pushes its expected value into a queue when it is issued. A monitor pops one entry at the falling edge of every cycle in which rd_valid is high, so every comparison falls on the cycle in which the result is due.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         ack_lo,
  input  logic         ack_hi,
  output logic [N-1:0] pend
);
  localparam int H = N / 2;

  logic [N-1:0] req_d;
  logic [N-1:0] rise;
  logic [N-1:0] clr;

  assign rise = req & ~req_d;
  assign clr  = {{(N - H){ack_hi}}, {H{ack_lo}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d <= '0;
      pend  <= '0;
    end else begin
      req_d <= req;
      pend  <= (pend & ~clr) | rise;
    end
  end

  AST_ACK_LO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_lo |=> ((pend[H-1:0] & ~$past(rise[H-1:0])) == '0)); // R6
  AST_ACK_HI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_hi |=> ((pend[N-1:H] & ~$past(rise[N-1:H])) == '0)); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ack_lo && !ack_hi) |=> ((pend & $past(pend)) == $past(pend))); // R5
  AST_SET_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(req & ~req_d)) == '0)); // R5
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int N = 16,
  parameter int H = N / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         sel_hi,
  input  logic [H-1:0] wdata,
  output logic [N-1:0] mask
);
  for (genvar g = 0; g < 2; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[g*H +: H] <= '1;
      end else if (we && (sel_hi == 1'(g))) begin
        mask[g*H +: H] <= ~wdata;
      end
    end
  end

  AST_LO_MASK_INV: assert property (@(posedge clk) disable iff (rst)
    (we && !sel_hi) |=> (mask[H-1:0] == ~$past(wdata)) &&
                        (mask[N-1:H] == $past(mask[N-1:H]))); // R2
  AST_HI_MASK_INV: assert property (@(posedge clk) disable iff (rst)
    (we && sel_hi) |=> (mask[N-1:H] == ~$past(wdata)) &&
                       (mask[H-1:0] == $past(mask[H-1:0]))); // R3
endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder #(
  parameter int N_LINES = 16,
  parameter int N_SRC   = 15,
  parameter int DATA_W  = 16,
  parameter int HALF_W  = N_LINES / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req,
  input  logic [N_SRC-1:0]   src_req,
  input  logic               wr_en,
  input  logic               wr_hi,
  input  logic               wr_off,
  input  logic [HALF_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [1:0]         rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               irq_o
);
  import irq_vec_pkg::*;

  localparam int LIW = $clog2(N_LINES);
  localparam int SIW = $clog2(N_SRC);

  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] active;
  logic [N_SRC-1:0]   src_q;
  logic               vec_found;
  logic [LIW-1:0]     vec_idx;
  logic               src_found;
  logic [SIW-1:0]     src_idx;
  logic [DATA_W-1:0]  src_code;
  logic [DATA_W-1:0]  rd_next;
  logic               ack_lo;
  logic               ack_hi;

  assign ack_lo = wr_en && !wr_off && !wr_hi;
  assign ack_hi = wr_en && !wr_off &&  wr_hi;
  assign active = pend & mask;

  irq_pend_bank #(.N(N_LINES)) u_pend (
    .clk(clk), .rst(rst), .req(req),
    .ack_lo(ack_lo), .ack_hi(ack_hi), .pend(pend)
  );

  irq_mask_regs #(.N(N_LINES), .H(HALF_W)) u_mask (
    .clk(clk), .rst(rst), .we(wr_en && wr_off),
    .sel_hi(wr_hi), .wdata(wr_data), .mask(mask)
  );

  irq_lowest_first #(.W(N_LINES), .IW(LIW)) u_vec_enc (
    .vec(active), .found(vec_found), .idx(vec_idx)
  );

  irq_lowest_first #(.W(N_SRC), .IW(SIW)) u_src_enc (
    .vec(src_q), .found(src_found), .idx(src_idx)
  );

  assign src_code = src_found ? DATA_W'((32'(src_idx) + 32'd1) << 2) : '0;

  always_comb begin
    case (rd_sel_e'(rd_sel))
      SEL_MASK: rd_next = DATA_W'(mask);
      SEL_VEC:  rd_next = vec_found ? DATA_W'(vec_idx) : '0;
      SEL_SRC:  rd_next = src_code;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      src_q    <= src_req;
      rd_valid <= rd_en;
      irq_o    <= |active;
      if (rd_en) rd_data <= rd_next;
    end
  end

  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |$past(pend & mask))); // R10
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R11
  AST_SRC_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd2 && src_q == '0) |=> (rd_data == '0)); // R9
endmodule

// File: tb/irq_vec_encoder_bench.sv
module irq_vec_encoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic [14:0] src_req = '0;
  logic        wr_en = 1'b0, wr_hi = 1'b0, wr_off = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_vec_encoder u_irq_vec_encoder (
    .clk(clk), .rst(rst), .req(req), .src_req(src_req),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_off(wr_off), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_o(irq_o)
  );

  // monitor: compares each read result in the cycle it is due
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] sel, input logic [15:0] e, input string t);
    rd_en = 1'b1; rd_sel = sel;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic hi, input logic off, input logic [7:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_run++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq_o actual %b expected %b", t, irq_o, e);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    idle(3);
    rst = 1'b0;
    idle(1);
    chk_irq(1'b0, "R1");
    do_read(2'd0, 16'hFFFF, "R1 mask");
    do_read(2'd1, 16'h0000, "R1 vector");
    do_read(2'd2, 16'h0000, "R1 source");

    req[5] = 1'b1;
    idle(2);
    chk_irq(1'b1, "R10 set");
    do_read(2'd1, 16'd5, "R8 single");

    req[3] = 1'b1; req[12] = 1'b1;
    idle(1);
    do_read(2'd1, 16'd3, "R8 lowest wins");

    do_write(1'b0, 1'b1, 8'h08);
    do_read(2'd0, 16'hFFF7, "R2 R4 low mask");
    do_read(2'd1, 16'd5, "R8 masked skip");

    do_write(1'b1, 1'b1, 8'hFF);
    do_read(2'd0, 16'h00F7, "R3 R4 high mask");

    do_write(1'b0, 1'b0, 8'h5A);
    do_read(2'd1, 16'd0, "R6 low ack");
    idle(1);
    chk_irq(1'b0, "R10 clear");

    do_write(1'b1, 1'b1, 8'h00);
    do_read(2'd1, 16'd12, "R6 R5 high kept, no relevel");
    chk_irq(1'b1, "R10 reenable");

    // acknowledge of high half in the same cycle as a rising edge on line 9
    wr_en = 1'b1; wr_hi = 1'b1; wr_off = 1'b0; wr_data = 8'hFF; req[9] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    do_read(2'd1, 16'd9, "R7 edge beats ack");

    do_write(1'b1, 1'b0, 8'h00);
    do_read(2'd1, 16'd0, "R6 high ack");
    do_read(2'd0, 16'hFFF7, "R6 ack leaves mask");

    src_req = 15'h4010;
    idle(1);
    do_read(2'd2, 16'd20, "R9 lowest source");
    src_req = 15'h4000;
    idle(1);
    do_read(2'd2, 16'd60, "R9 top source");
    src_req = 15'h0001;
    idle(1);
    do_read(2'd2, 16'd4, "R9 source zero");
    src_req = 15'h0000;
    idle(1);
    do_read(2'd2, 16'd0, "R9 none");
    do_read(2'd3, 16'd0, "R11 unused select");

    idle(3);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule